// File: doc/BRIEF.md
# Infrared Transmit Timing Generator with Self-Stop

This block supplies all the timing for an infrared remote-control sender. A free-running phase counter cuts the oscillator clock into 12-clock subcarrier periods. A pulse that is high for part of each period becomes the carrier. A static option sets the high part to a quarter or a third of the period. A control timer counts subcarrier periods. Its full cycle is one repetition of the code word. Each group of equal bit-time slices in that cycle carries one code bit.

The code word arrives on a parallel input and is captured into a shift register whenever the control timer wraps back to zero. It is sent most significant bit first. The carrier reaches the output pin only while the current bit is 1. The block stops itself when the key input has been idle long enough and the timer is finishing a repetition. While stopped it holds a clock enable low, freezes the timer and keeps the pin low. A wake pulse from the key matrix starts it again from a clean period boundary.

Top module: `irtx_timing`

## Requirements
- R1: `sub_tick` is high for exactly one clock in every 12, on the last clock of each subcarrier period (phase 11, counting phases from 0 after reset or wake).
- R2: With `duty_sel` = 0 and the current bit 1, `ir_out` is high on phases 0, 1 and 2 of each period and low on the other 9.
- R3: With `duty_sel` = 1 and the current bit 1, `ir_out` is high on phases 0 to 3 of each period and low on the other 8.
- R4: `timer_val` increases by one after each `sub_tick` and wraps from BIT_PULSES*BITS-1 to 0.
- R5: Each code bit is held for BIT_PULSES subcarrier periods, and the bits go out in order from the most significant bit `code_word[BITS-1]` down to bit 0.
- R6: `code_word` is sampled on the clock edge where `timer_val` wraps to 0, and that value is sent during the repetition that follows. The repetition right after reset sends all zeros.
- R7: During a bit whose value is 0, `ir_out` stays low for the whole bit time.
- R8: When `timer_val` wraps and at least IDLE_PERIODS subcarrier periods have been counted with `key_held` low, `running` falls on that same edge and `timer_val` reads 0.
- R9: While `running` is low, `ir_out` and `sub_tick` stay low and `timer_val` does not change.
- R10: A one-clock `wake` pulse while stopped sets `running` on the next edge. Phase and timer then restart from 0, and the word captured at the stop is sent.
- R11: Any clock with `key_held` high clears the idle count, so a wrap that follows fewer than IDLE_PERIODS counted periods does not stop the block.
- R12: `wake` asserted while running has no effect on the timer, the carrier or the output.
- R13: After reset, `running` is 1, `timer_val` is 0 and `ir_out` and `sub_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| duty_sel | input | 1 | Carrier duty option: 0 = one quarter, 1 = one third |
| key_held | input | 1 | High while any key is pressed |
| wake | input | 1 | Start request from a key press |
| code_word | input | BITS | Word to send in the next repetition |
| ir_out | output | 1 | Gated carrier to the emitter driver |
| running | output | 1 | High while the clock enable is open |
| sub_tick | output | 1 | One-clock strobe at the end of each subcarrier period |
| timer_val | output | log2(BIT_PULSES*BITS) | Control timer count |

## Verification
The bench uses a reduced setup of four bits and four periods per bit. It sweeps every possible code word under both duty options and compares the output clock by clock against a closed-form model. That model separates errors in bit order, in the load instant and in the duty width. It then uses several key-release patterns: a release at the start of a repetition, a release late in a repetition, and a brief re-press. These show whether the idle count is compared at the right wrap and cleared by the key. Wake is tried while stopped with the key held and with it released, and also while running, which tells a correct restart apart from a wrongly retriggered one.

// File: rtl/irtx_pkg.sv
// Package: shared types for the infrared transmit timing generator.
// Assumes nothing beyond IEEE 1800-2017 enums.
package irtx_pkg;

    // Carrier duty option selected by a static pin
    typedef enum logic {
        DUTY_QUARTER = 1'b0,
        DUTY_THIRD   = 1'b1
    } duty_e;

endpackage

// File: rtl/irtx_subdiv.sv
// Subcarrier divider: counts DIV oscillator clocks per subcarrier period,
// flags the last clock of each period and forms the carrier pulse, high
// for the first HI_Q or HI_T clocks. Assumes HI_T and HI_Q below DIV.
// The phase is forced to 0 whenever run is low.
module irtx_subdiv
    import irtx_pkg::*;
#(
    parameter int DIV  = 12,
    parameter int HI_Q = 3,
    parameter int HI_T = 4,
    localparam int PW  = $clog2(DIV)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  duty_e duty,
    output logic  tick,
    output logic  pulse
);

    logic [PW-1:0] phase;
    logic [PW-1:0] hi_len;

    // Phase counter, parked at 0 while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
        end else if (phase == PW'(DIV - 1)) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Carrier high length and period strobe
    always_comb begin
        hi_len = (duty == DUTY_THIRD) ? PW'(HI_T) : PW'(HI_Q);
        tick   = run && (phase == PW'(DIV - 1));
        pulse  = run && (phase < hi_len);
    end

endmodule

// File: rtl/irtx_ctl_timer.sv
// Control timer: counts subcarrier periods modulo TOTAL and flags the
// period that closes a repetition. Assumes tick is a one-clock strobe.
module irtx_ctl_timer #(
    parameter int TOTAL = 4096,
    localparam int TW   = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [TW-1:0] count,
    output logic          wrap
);

    // Repetition-closing strobe
    always_comb begin
        wrap = tick && (count == TW'(TOTAL - 1));
    end

    // Period counter with explicit wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wrap) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/irtx_code_shift.sv
// Code shifter: captures the code word at each repetition wrap and moves
// to the next bit, most significant first, every BIT_PULSES periods.
// Assumes TOTAL periods per repetition equals BIT_PULSES * BITS, so the
// local period count and the control timer stay aligned.
module irtx_code_shift #(
    parameter int BITS       = 64,
    parameter int BIT_PULSES = 64,
    localparam int BW        = $clog2(BIT_PULSES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wrap,
    input  logic [BITS-1:0] code_word,
    output logic            cur_bit
);

    logic [BITS-1:0] sreg;
    logic [BW-1:0]   pcnt;
    logic            bit_end;

    // End of the current bit time
    always_comb begin
        bit_end = tick && (pcnt == BW'(BIT_PULSES - 1));
        cur_bit = sreg[BITS-1];
    end

    // Periods elapsed within the current bit
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            pcnt <= '0;
        end else if (bit_end) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // Load at repetition start, shift left at each bit end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (wrap) begin
            sreg <= code_word;
        end else if (bit_end) begin
            sreg <= {sreg[BITS-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/irtx_sleep.sv
// Sleep control: counts subcarrier periods with no key held, saturating
// at IDLE, and drops the run enable at a repetition wrap once the count
// is reached. A wake pulse sets the enable again and wins over a stop on
// the same edge. Assumes wrap implies tick.
module irtx_sleep #(
    parameter int IDLE = 1008,
    localparam int IW  = $clog2(IDLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wrap,
    input  logic key_held,
    input  logic wake,
    output logic run
);

    logic [IW-1:0] idle_cnt;
    logic          idle_done;

    // Timeout reached
    always_comb begin
        idle_done = (idle_cnt >= IW'(IDLE));
    end

    // Idle period counter, cleared by any key activity
    always_ff @(posedge clk) begin
        if (!rst_n || key_held) begin
            idle_cnt <= '0;
        end else if (tick && !idle_done) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Set-reset run enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b1;
        end else if (wake) begin
            run <= 1'b1;
        end else if (wrap && idle_done) begin
            run <= 1'b0;
        end
    end

endmodule

// File: rtl/irtx_timing.sv
// Top: infrared transmit timing generator. Ties the subcarrier divider,
// control timer, code shifter and sleep control together and gates the
// carrier with the current code bit. Assumes duty_sel is static over a
// repetition and wake is synchronous to clk.
module irtx_timing
    import irtx_pkg::*;
#(
    parameter int DIV          = 12,
    parameter int HI_QUARTER   = 3,
    parameter int HI_THIRD     = 4,
    parameter int BIT_PULSES   = 64,
    parameter int BITS         = 64,
    parameter int IDLE_PERIODS = 1008,
    localparam int TOTAL       = BIT_PULSES * BITS,
    localparam int TW          = $clog2(TOTAL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            duty_sel,
    input  logic            key_held,
    input  logic            wake,
    input  logic [BITS-1:0] code_word,
    output logic            ir_out,
    output logic            running,
    output logic            sub_tick,
    output logic [TW-1:0]   timer_val
);

    logic  run;
    logic  tick;
    logic  pulse;
    logic  wrap;
    logic  cur_bit;
    duty_e duty;

    // Static option decode
    always_comb begin
        duty = duty_e'(duty_sel);
    end

    irtx_subdiv #(
        .DIV  (DIV),
        .HI_Q (HI_QUARTER),
        .HI_T (HI_THIRD)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .duty  (duty),
        .tick  (tick),
        .pulse (pulse)
    );

    irtx_ctl_timer #(
        .TOTAL (TOTAL)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (timer_val),
        .wrap  (wrap)
    );

    irtx_code_shift #(
        .BITS       (BITS),
        .BIT_PULSES (BIT_PULSES)
    ) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wrap      (wrap),
        .code_word (code_word),
        .cur_bit   (cur_bit)
    );

    irtx_sleep #(
        .IDLE (IDLE_PERIODS)
    ) u_slp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wrap     (wrap),
        .key_held (key_held),
        .wake     (wake),
        .run      (run)
    );

    // Output gating
    always_comb begin
        ir_out   = pulse && cur_bit;
        running  = run;
        sub_tick = tick;
    end

endmodule

// File: rtl/irtx_timing_chk.sv
// Checker: temporal properties of the timing generator ports.
// Assumes synchronous active-low reset.
module irtx_timing_chk #(
    parameter int TW    = 12,
    parameter int TOTAL = 4096
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wake,
    input logic          running,
    input logic          ir_out,
    input logic          sub_tick,
    input logic [TW-1:0] timer_val
);

    // R9: pin silent while stopped
    assert_quiet_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!ir_out && !sub_tick));

    // R9: timer frozen across stopped clocks
    assert_timer_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running ##1 !running) |-> $stable(timer_val));

    // R4: timer only steps by one or wraps to zero
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(timer_val) |->
            ((timer_val == $past(timer_val) + 1'b1) ||
             (timer_val == '0 && $past(timer_val) == TW'(TOTAL - 1))));

    // R10: wake opens the enable on the next edge
    assert_wake_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> running);

    // R8: stopping happens only at the wrap to zero
    assert_stop_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (timer_val == '0));

endmodule

bind irtx_timing irtx_timing_chk #(
    .TW    (TW),
    .TOTAL (TOTAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake      (wake),
    .running   (running),
    .ir_out    (ir_out),
    .sub_tick  (sub_tick),
    .timer_val (timer_val)
);

// File: tb/tb_irtx_timing.sv
module tb_irtx_timing;

    localparam int CLK_PERIOD = 10;
    localparam int DIVB  = 12;
    localparam int BP    = 4;
    localparam int NB    = 4;
    localparam int IDLE  = 6;
    localparam int SLOTS = BP * NB;
    localparam int REP   = DIVB * SLOTS;
    localparam int TWB   = $clog2(SLOTS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          duty_sel = 1'b0;
    logic          key_held = 1'b0;
    logic          wake = 1'b0;
    logic [NB-1:0] code_word = '0;
    logic          ir_out;
    logic          running;
    logic          sub_tick;
    logic [TWB-1:0] timer_val;

    int checks = 0;
    int fails  = 0;

    irtx_timing #(
        .DIV          (DIVB),
        .HI_QUARTER   (3),
        .HI_THIRD     (4),
        .BIT_PULSES   (BP),
        .BITS         (NB),
        .IDLE_PERIODS (IDLE)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_sel  (duty_sel),
        .key_held  (key_held),
        .wake      (wake),
        .code_word (code_word),
        .ir_out    (ir_out),
        .running   (running),
        .sub_tick  (sub_tick),
        .timer_val (timer_val)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One full repetition, checked every clock; entered and left at sample j=0
    task automatic run_rep(input logic [NB-1:0] cw, input int hi, input logic [NB-1:0] nxt,
                           input int rel_j, input int pulse_j, input int wake_j);
        for (int j = 0; j < REP; j++) begin
            logic eb;
            string msg;
            eb = cw[NB - 1 - j / (DIVB * BP)];
            if (!eb)
                msg = "R7 R5 R6 zero bit silent";
            else if (hi == 3)
                msg = "R2 R5 R6 quarter duty carrier";
            else
                msg = "R3 R5 R6 third duty carrier";
            chk(msg, int'(ir_out), int'(eb && ((j % DIVB) < hi)));
            chk("R4 timer count", int'(timer_val), (j / DIVB) % SLOTS);
            chk("R1 period strobe", int'(sub_tick), int'((j % DIVB) == DIVB - 1));
            chk("R11 R12 running kept", int'(running), 1);
            if (j == 5) code_word = nxt;
            if (j == rel_j) key_held = 1'b0;
            if (pulse_j >= 0 && j == pulse_j) key_held = 1'b1;
            if (pulse_j >= 0 && j == pulse_j + 1) key_held = 1'b0;
            if (wake_j >= 0 && j == wake_j) wake = 1'b1;
            if (wake_j >= 0 && j == wake_j + 1) wake = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic check_stopped(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R8 running cleared", int'(running), 0);
            chk("R9 pin low while stopped", int'(ir_out), 0);
            chk("R9 no strobe while stopped", int'(sub_tick), 0);
            chk("R9 timer frozen at zero", int'(timer_val), 0);
            @(posedge clk); #1;
        end
    endtask

    task automatic do_wake();
        wake = 1'b1;
        @(posedge clk); #1;
        wake = 1'b0;
        chk("R10 running after wake", int'(running), 1);
        chk("R10 timer restarts at zero", int'(timer_val), 0);
    endtask

    initial begin
        logic [NB-1:0] prev;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R13 reset running", int'(running), 1);
        chk("R13 reset timer", int'(timer_val), 0);
        chk("R13 reset pin", int'(ir_out), 0);
        chk("R13 reset strobe", int'(sub_tick), 0);

        // Sweep all code words under both duty options (R6: first rep is zeros)
        key_held = 1'b1;
        prev = '0;
        for (int i = 0; i < 2 * (1 << NB) + 1; i++) begin
            logic [NB-1:0] nx;
            duty_sel = (i > (1 << NB));
            nx = NB'(i);
            run_rep(prev, duty_sel ? 4 : 3, nx, -1, -1, -1);
            prev = nx;
        end

        // R8: release at repetition start, R12: wake while running
        duty_sel = 1'b0;
        run_rep(prev, 3, 4'b1011, 0, -1, 40);
        check_stopped(40);

        // R10 with key held, then R11 brief re-press keeps it running
        key_held = 1'b1;
        do_wake();
        run_rep(4'b1011, 3, 4'b0110, -1, -1, -1);
        run_rep(4'b0110, 3, 4'b1001, 0, 150, -1);
        run_rep(4'b1001, 3, 4'b0011, -1, -1, -1);
        check_stopped(30);

        // R10 with key released: one repetition then stop again
        do_wake();
        run_rep(4'b0011, 3, 4'b0011, -1, -1, -1);
        check_stopped(20);

        // R11 late release: too few idle periods at the wrap
        key_held = 1'b1;
        duty_sel = 1'b1;
        do_wake();
        run_rep(4'b0011, 4, 4'b0101, 144, -1, -1);
        run_rep(4'b0101, 4, 4'b1110, -1, -1, -1);
        check_stopped(10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule